// File: doc/BRIEF.md
# Programmable ISA Bus Clock Generator

The block derives the ISA bus clock from the PCI clock. An 8-bit configuration byte, written on the PCI clock and readable at any time, picks the ratio. When its custom-select bit is clear the bus clock is the PCI clock divided by four. When that bit is set, a 3-bit source code picks one of seven integer divisors, or a straight pass-through of a separate oscillator input.

Software retunes the clock in three steps. It clears the custom-select bit, writes the new source code, and then sets the bit again. The block absorbs that sequence without short pulses. A new divisor is loaded only at the boundary of a full output period. Moving between the divided clock and the oscillator goes through a two-sided clock mux. In that mux one side may turn on only after the other side has turned off.

Top module: `isa_clkgen`

## Requirements
- R1: A write (cfg_we high at a pci_clk rising edge) stores cfg_wdata, and cfg_rdata shows the stored byte from the next cycle on. Bits 7, 6, 5 and 3..0 read back exactly as written.
- R2: Bit 4 is reserved. It always reads 0, and writing 1 to it has no effect on cfg_rdata.
- R3: While rst_n is low, cfg_rdata is 8'h00 and bus_clk is low, with no clock edge needed. After release, bus_clk runs at pci_clk/4: low for 2 cycles, high for 2.
- R4: With bit 3 at 0, bus_clk is pci_clk/4 for every value of bits 2..0, including 3'b111.
- R5: With bit 3 at 1, bits 2..0 select these divisors: 000 gives 3, 001 gives 2, 010 gives 4, 011 gives 6, 100 gives 5, 101 gives 10, 110 gives 12. For a divisor N, the low phase lasts (N+1)/2 pci_clk cycles and the high phase lasts N/2 cycles (integer division).
- R6: With bit 3 at 1 and bits 2..0 at 111, bus_clk follows osc_clk: it is high while osc_clk is high and low while osc_clk is low.
- R7: A divisor change is applied only where a high phase ends. During the three-step retune, every high or low phase is a complete phase of the old divisor, of 4, or of the new divisor.
- R8: The divided path and the oscillator path are never gated onto bus_clk at the same time. After a return from the oscillator, bus_clk again shows only the selected divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pci_clk | input | 1 | PCI clock; source of the divided clock and clock of the register |
| osc_clk | input | 1 | Oscillator clock passed through on code 111 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to store |
| cfg_rdata | output | 8 | Stored configuration byte |
| bus_clk | output | 1 | Generated ISA bus clock |

## Verification
A wrong divide counter or phase split shows up within one output period as a high or low run of the wrong length on bus_clk. The bench measures these runs for every source code. A divisor loaded mid-period leaves a run that belongs to no legal divisor, and it does so in the period where the retune happens. A mux handshake fault shows up at once. Either bus_clk fails to follow osc_clk within a few tens of cycles, or the divided clock leaks through while the oscillator is selected.

// File: rtl/isa_clkgen_pkg.sv
package isa_clkgen_pkg;

   localparam int CFG_W       = 8;
   localparam int EN_BIT      = 3;
   localparam int RSV_BIT     = 4;
   localparam int DFLT_RATIO  = 4;
   localparam int MAX_RATIO   = 12;
   localparam logic [2:0] OSC_CODE = 3'b111;

   // Effective divisor of the PCI clock for a register setting.
   // The oscillator code keeps the divider at its default ratio.
   function automatic int unsigned ratio_of(input logic en, input logic [2:0] code);
      if (!en) return DFLT_RATIO;
      case (code)
         3'b000:  return 3;
         3'b001:  return 2;
         3'b010:  return 4;
         3'b011:  return 6;
         3'b100:  return 5;
         3'b101:  return 10;
         3'b110:  return 12;
         default: return DFLT_RATIO;
      endcase
   endfunction

endpackage

// File: rtl/isa_clkgen_regs.sv
module isa_clkgen_regs #(
   parameter int             W       = 8,
   parameter logic [W-1:0]   RST_VAL = '0,
   parameter logic [W-1:0]   WMASK   = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= RST_VAL & WMASK;
      else if (we) cfg_q <= wdata & WMASK;
   end

   assign rdata = cfg_q;

endmodule

// File: rtl/isa_clkgen_div.sv
module isa_clkgen_div #(
   parameter int CNT_W   = 4,
   parameter int RST_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] n_req,
   output logic             div_q,
   output logic [CNT_W-1:0] n_cur
);

   if (CNT_W < 2) begin : g_bad_width
      $error("isa_clkgen_div: CNT_W must be at least 2");
   end
   if (RST_DIV < 2 || RST_DIV >= (1 << CNT_W)) begin : g_bad_rst
      $error("isa_clkgen_div: RST_DIV out of range");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d, cur_q, cur_d, lo_d;
   logic             wrap;

   always_comb begin
      wrap  = (cnt_q == cur_q - 1'b1);
      cur_d = wrap ? n_req : cur_q;
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      lo_d  = (cur_d + 1'b1) >> 1;
   end

   // Low phase first, then high; a new ratio loads as the high phase ends.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= CNT_W'(RST_DIV);
         div_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         cur_q <= cur_d;
         div_q <= (cnt_d >= lo_d);
      end
   end

   assign n_cur = cur_q;

endmodule

// File: rtl/isa_clkgen_gmux.sv
module isa_clkgen_gmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic pci_clk,
   input  logic osc_clk,
   input  logic rst_n,
   input  logic want_osc,
   input  logic div_clk,
   output logic pci_sel,
   output logic osc_sel,
   output logic clk_out
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("isa_clkgen_gmux: SYNC_STAGES must be at least 2");
   end

   localparam int PRE = SYNC_STAGES - 1;

   logic [PRE-1:0] p_pipe, o_pipe;
   logic           p_req, o_req;

   assign p_req = ~want_osc & ~osc_sel;
   assign o_req =  want_osc & ~pci_sel;

   always_ff @(posedge pci_clk or negedge rst_n) begin
      if (!rst_n) p_pipe <= '0;
      else        p_pipe <= PRE'({p_pipe, p_req});
   end

   // Final stage on the falling edge, moved only while the divided clock is low.
   always_ff @(negedge pci_clk or negedge rst_n) begin
      if (!rst_n)        pci_sel <= 1'b0;
      else if (!div_clk) pci_sel <= p_pipe[PRE-1];
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) o_pipe <= '0;
      else        o_pipe <= PRE'({o_pipe, o_req});
   end

   always_ff @(negedge osc_clk or negedge rst_n) begin
      if (!rst_n) osc_sel <= 1'b0;
      else        osc_sel <= o_pipe[PRE-1];
   end

   assign clk_out = (div_clk & pci_sel) | (osc_clk & osc_sel);

endmodule

// File: rtl/isa_clkgen.sv
module isa_clkgen
   import isa_clkgen_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             pci_clk,
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             bus_clk
);

   if ((1 << CNT_W) <= MAX_RATIO) begin : g_bad_cnt
      $error("isa_clkgen: CNT_W too narrow for the largest ratio");
   end

   localparam logic [CFG_W-1:0] CFG_WMASK = ~(CFG_W'(1) << RSV_BIT);

   logic [CFG_W-1:0] cfg_q;
   logic             sel_en, want_osc, div_clk, pci_sel, osc_sel;
   logic [2:0]       src_code;
   logic [CNT_W-1:0] n_req, div_n;

   isa_clkgen_regs #(
      .W       (CFG_W),
      .RST_VAL ('0),
      .WMASK   (CFG_WMASK)
   ) u_regs (
      .clk   (pci_clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_q)
   );

   assign sel_en   = cfg_q[EN_BIT];
   assign src_code = cfg_q[2:0];
   assign want_osc = sel_en && (src_code == OSC_CODE);
   assign n_req    = CNT_W'(ratio_of(sel_en, src_code));

   isa_clkgen_div #(
      .CNT_W   (CNT_W),
      .RST_DIV (DFLT_RATIO)
   ) u_div (
      .clk   (pci_clk),
      .rst_n (rst_n),
      .n_req (n_req),
      .div_q (div_clk),
      .n_cur (div_n)
   );

   isa_clkgen_gmux #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_gmux (
      .pci_clk  (pci_clk),
      .osc_clk  (osc_clk),
      .rst_n    (rst_n),
      .want_osc (want_osc),
      .div_clk  (div_clk),
      .pci_sel  (pci_sel),
      .osc_sel  (osc_sel),
      .clk_out  (bus_clk)
   );

   assign cfg_rdata = cfg_q;

endmodule

// File: rtl/isa_clkgen_chk.sv
module isa_clkgen_chk #(
   parameter int CNT_W = 4
) (
   input logic             pci_clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [7:0]       cfg_wdata,
   input logic [7:0]       cfg_rdata,
   input logic             bus_clk,
   input logic             div_clk,
   input logic [CNT_W-1:0] div_n,
   input logic             pci_sel,
   input logic             osc_sel
);

   logic [7:0] hi_len, lo_len;

   always_ff @(posedge pci_clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         hi_len <= div_clk ? ((hi_len == 8'hFF) ? hi_len : hi_len + 8'd1) : 8'd0;
         lo_len <= div_clk ? 8'd0 : ((lo_len == 8'hFF) ? lo_len : lo_len + 8'd1);
      end
   end

   p_readback_r1: assert property (@(posedge pci_clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == {$past(cfg_wdata[7:5]), 1'b0, $past(cfg_wdata[3:0])}));

   p_rsv_zero_r2: assert property (@(posedge pci_clk) disable iff (!rst_n)
      cfg_rdata[4] == 1'b0);

   always @(posedge pci_clk) begin
      if (!rst_n) begin
         p_reset_quiet_r3: assert (bus_clk == 1'b0 && cfg_rdata == 8'h00);
      end
   end

   p_phase_cap_r5: assert property (@(posedge pci_clk) disable iff (!rst_n)
      (hi_len <= 8'd6) && (lo_len <= 8'd6));

   p_load_at_fall_r7: assert property (@(posedge pci_clk) disable iff (!rst_n)
      !$stable(div_n) |-> $fell(div_clk));

   p_one_source_r8: assert property (@(posedge pci_clk) disable iff (!rst_n)
      !(pci_sel && osc_sel));

endmodule

bind isa_clkgen isa_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
   .pci_clk   (pci_clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .bus_clk   (bus_clk),
   .div_clk   (div_clk),
   .div_n     (div_n),
   .pci_sel   (pci_sel),
   .osc_sel   (osc_sel)
);

// File: tb/isa_clkgen_tb.sv
module isa_clkgen_tb;

   logic       pci_clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic       cfg_we  = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       bus_clk;

   int  n_total = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 pci_clk = ~pci_clk;
   always #7 osc_clk = ~osc_clk;

   isa_clkgen u_dut (
      .pci_clk   (pci_clk),
      .osc_clk   (osc_clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .bus_clk   (bus_clk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio(input logic [2:0] c);
      case (c)
         3'd0: return 3;   3'd1: return 2;   3'd2: return 4;  3'd3: return 6;
         3'd4: return 5;   3'd5: return 10;  3'd6: return 12; default: return 4;
      endcase
   endfunction

   function automatic bit phase_ok(input bit lvl, input int len, input int a, input int b);
      int cand [3];
      cand[0] = a; cand[1] = 4; cand[2] = b;
      foreach (cand[i]) begin
         if (lvl && len == cand[i] / 2) return 1'b1;
         if (!lvl && len == (cand[i] + 1) / 2) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge pci_clk);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge pci_clk);
      cfg_we = 1'b0;
   endtask

   task automatic runs(output int lo, output int hi);
      do @(negedge pci_clk); while (bus_clk !== 1'b1);
      do @(negedge pci_clk); while (bus_clk !== 1'b0);
      lo = 0;
      while (bus_clk === 1'b0) begin lo++; @(negedge pci_clk); end
      hi = 0;
      while (bus_clk === 1'b1) begin hi++; @(negedge pci_clk); end
   endtask

   task automatic expect_div(input int n, input string req);
      int lo, hi;
      for (int k = 0; k < 3; k++) begin
         runs(lo, hi);
         chk(lo == (n + 1) / 2, {req, " low phase"}, lo, (n + 1) / 2);
         chk(hi == n / 2, {req, " high phase"}, hi, n / 2);
      end
   endtask

   // Retune monitor for R7: every complete phase must belong to old, 4 or new.
   bit sw_on = 1'b0;
   int mon_old = 4, mon_new = 4;
   int mon_len = 0;
   bit mon_prev = 1'b0, mon_seen = 1'b0;

   always @(negedge pci_clk) begin
      if (!sw_on) begin
         mon_seen = 1'b0; mon_len = 0; mon_prev = bus_clk;
      end else if (bus_clk !== mon_prev) begin
         if (mon_seen)
            chk(phase_ok(mon_prev, mon_len, mon_old, mon_new), "R7 retune phase", mon_len, -1);
         mon_seen = 1'b1; mon_len = 1; mon_prev = bus_clk;
      end else begin
         mon_len++;
      end
   end

   logic [2:0] cur_code = 3'd0;
   bit         cur_en   = 1'b0;

   task automatic retune(input logic [2:0] code, input logic [2:0] hi_bits);
      wr({hi_bits, 1'b0, 1'b0, cur_code});
      wr({hi_bits, 1'b0, 1'b0, code});
      wr({hi_bits, 1'b0, 1'b1, code});
      cur_code = code; cur_en = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge pci_clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      // R3: reset state
      repeat (4) @(negedge pci_clk);
      chk(bus_clk === 1'b0, "R3 bus low in reset", bus_clk, 0);
      chk(cfg_rdata === 8'h00, "R3 reg reset", cfg_rdata, 0);
      rst_n = 1'b1;
      expect_div(4, "R3 after reset");

      // R1/R2: exhaustive write/readback
      for (int v = 0; v < 256; v++) begin
         wr(8'(v));
         chk(cfg_rdata === (8'(v) & 8'hEF), "R1 readback", cfg_rdata, v & 8'hEF);
         if (v[4]) chk(cfg_rdata[4] === 1'b0, "R2 reserved bit", cfg_rdata[4], 0);
      end
      wr(8'h00);
      repeat (30) @(negedge pci_clk);

      // R4: select code ignored while custom select is off
      for (int c = 0; c < 8; c++) begin
         wr({5'b0, 3'(c)});
         cur_code = 3'(c);
         repeat (10) @(negedge pci_clk);
         expect_div(4, "R4 code ignored");
      end

      // R5 + R7: each divider code through the three-step retune
      for (int c = 0; c < 7; c++) begin
         mon_old = cur_en ? ratio(cur_code) : 4;
         mon_new = ratio(3'(c));
         sw_on = 1'b1;
         retune(3'(c), 3'(c));
         repeat (40) @(negedge pci_clk);
         sw_on = 1'b0;
         expect_div(ratio(3'(c)), "R5 divisor");
      end

      // R6: oscillator pass-through
      retune(3'b111, 3'b000);
      repeat (40) @(negedge pci_clk);
      for (int k = 0; k < 6; k++) begin
         @(posedge osc_clk); #1;
         chk(bus_clk === 1'b1, "R6 osc high", bus_clk, 1);
         @(negedge osc_clk); #1;
         chk(bus_clk === 1'b0, "R6 osc low", bus_clk, 0);
      end

      // R8: back to a divided clock, only that clock is visible
      retune(3'b100, 3'b000);
      repeat (40) @(negedge pci_clk);
      expect_div(5, "R8 return from osc");
      retune(3'b001, 3'b000);
      repeat (20) @(negedge pci_clk);
      expect_div(2, "R8 divide by 2");

      // R3: reset in the middle of a high phase
      do @(negedge pci_clk); while (bus_clk !== 1'b1);
      #1 rst_n = 1'b0;
      #1;
      chk(bus_clk === 1'b0, "R3 async reset low", bus_clk, 0);
      chk(cfg_rdata === 8'h00, "R3 async reset reg", cfg_rdata, 0);
      repeat (3) @(negedge pci_clk);
      rst_n = 1'b1;
      cur_code = 3'd0; cur_en = 1'b0;
      expect_div(4, "R3 after second reset");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule